// File: doc/BRIEF.md
# Overlay Pixel Unpack and Alpha Compositor

This block is a streaming pixel stage that lays an on-screen overlay over a video stream. Each input beat carries one overlay storage unit and the video pixel it sits on. The block keeps the storage width and the colour format as two separate settings. When the storage width is 8 bits, the colour format is ignored and the byte is an index into a 256-entry palette. Wider storage units hold a pixel in one of five formats, and any bytes the format does not use are padding.

After decoding, the block works out an effective alpha. It takes a per-pixel alpha whose meaning depends on the format, multiplies it by a global alpha, and forces the result to zero when the colour key matches. It then mixes the overlay colour into the video pixel, channel by channel. A one-bit colour-space tag is carried through with each beat and does not change the arithmetic. The palette is loaded through a small write port. An index write comes first. Each later data write stores a 32-bit entry at the index last written.

Top module: `osd_blend`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: The storage width code cfg_bpp selects the live bits of in_word: 01 = 8 bits [7:0], 10 = 16 bits [15:0], 11 or 00 = all 32 bits. The other bits are padding and have no effect. With code 01, the pixel is always a palette index, whatever cfg_mode holds.
- R3: cfg_mode selects the format. Codes 1, 2 and 3 are the 16-bit formats; code 4 and codes 5..7 all mean 8888. Channel a is the top output byte [23:16] and channel c is the bottom byte [7:0].
  - 0 = indexed: the palette entry supplies channels [23:0] and alpha [31:24].
  - 1 = 565: a = [15:11], b = [10:5], c = [4:0].
  - 2 = 555: spare bit [15], a = [14:10], b = [9:5], c = [4:0].
  - 3 = 444: spare bits [15:12], a = [11:8], b = [7:4], c = [3:0].
  - 8888: alpha = [31:24], channels = [23:0].
  - A narrow channel becomes 8 bits by repeating its top bits below it.
- R4: A write with pal_wr=1 and pal_sel=0 sets the palette pointer to pal_wdata[7:0]. A write with pal_wr=1 and pal_sel=1 stores pal_wdata at the entry the pointer names. The pointer keeps its value, so repeated data writes go to the same entry.
- R5: When cfg_key_en is 1 and the pixel matches cfg_key, the effective alpha is 0 and the output equals the video pixel. The compare width depends on the format:
  - 16-bit formats: bits [15:0].
  - 8888: bits [23:0].
  - Indexed: the 8-bit index.
- R6: With cfg_lalpha_en=1, the local alpha depends on the format. With cfg_lalpha_en=0, the local alpha is 255.
  - 8888 and indexed: the alpha byte.
  - 555: 0 if spare bit 15 is set, otherwise 255.
  - 444: 0 if any of spare bits [15:12] is set, otherwise 255.
  - 565: always 255.
- R7: The global alpha is cfg_galpha when cfg_galpha_en=1 and 255 otherwise. The effective alpha is round(local*global/255).
- R8: Each output channel is round((a*overlay + (255-a)*video)/255). a=255 gives the overlay colour and a=0 gives the video pixel.
- R9: A beat accepted at a rising edge reaches out_valid after the second edge that follows (three register stages). in_ready is low while out_valid is high and out_ready is low. A stalled output holds its value.
- R10: out_yuv repeats the cfg_yuv value sampled when the beat was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 3 | Colour format code |
| cfg_bpp | input | 2 | Storage width code |
| cfg_key_en | input | 1 | Colour key enable |
| cfg_lalpha_en | input | 1 | Per-pixel alpha enable |
| cfg_galpha_en | input | 1 | Global alpha enable |
| cfg_yuv | input | 1 | Colour-space tag carried with beats |
| cfg_key | input | 32 | Colour key value |
| cfg_galpha | input | 8 | Global alpha value |
| pal_wr | input | 1 | Palette write strobe |
| pal_sel | input | 1 | 0 = pointer write, 1 = entry write |
| pal_wdata | input | 32 | Palette write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_word | input | 32 | Overlay storage unit |
| in_video | input | 24 | Underlying video pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_pix | output | 24 | Blended pixel |
| out_yuv | output | 1 | Colour-space tag of the output pixel |

## Verification
The bench builds the block with the default index width of 8. This gives a palette of 256 entries. Every entry is loaded and can then be reached by random indexed pixels, and the indexed colour key compares a full byte. Random rounds also draw all four storage codes and all eight format codes. That covers the reserved codes, the padding masks and the case where 8-bit storage overrides the format. Random downstream stalls exercise the hold and backpressure paths.

// File: rtl/osd_blend.sv
module osd_blend #(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_mode,
  input  logic [1:0]  cfg_bpp,
  input  logic        cfg_key_en,
  input  logic        cfg_lalpha_en,
  input  logic        cfg_galpha_en,
  input  logic        cfg_yuv,
  input  logic [31:0] cfg_key,
  input  logic [7:0]  cfg_galpha,
  input  logic        pal_wr,
  input  logic        pal_sel,
  input  logic [31:0] pal_wdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  input  logic [23:0] in_video,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_pix,
  output logic        out_yuv
);
  localparam int PAL_N = 1 << IDX_W;
  localparam logic [2:0] F_IDX = 3'd0, F_565 = 3'd1, F_555 = 3'd2, F_444 = 3'd3;

  function automatic logic [7:0] div255(input logic [16:0] x);
    logic [16:0] t;
    t = x + 17'd128;
    return 8'((t + (t >> 8)) >> 8);
  endfunction

  logic [31:0] pal [PAL_N];
  logic [IDX_W-1:0] pal_ptr;

  always_ff @(posedge clk)
    if (pal_wr && pal_sel) pal[pal_ptr] <= pal_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pal_ptr <= '0;
    else if (pal_wr && !pal_sel) pal_ptr <= pal_wdata[IDX_W-1:0];

  logic go;
  assign go       = !out_valid || out_ready;
  assign in_ready = go;

  logic [31:0] wmask;
  always_comb
    case (cfg_bpp)
      2'b01:   wmask = 32'h0000_00FF;
      2'b10:   wmask = 32'h0000_FFFF;
      default: wmask = 32'hFFFF_FFFF;
    endcase

  logic        v1, yuv1;
  logic [31:0] w1, p1;
  logic [23:0] vid1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v1 <= 1'b0;
    else if (go) v1 <= in_valid;

  always_ff @(posedge clk)
    if (go) begin
      w1   <= in_word & wmask;
      vid1 <= in_video;
      yuv1 <= cfg_yuv;
      p1   <= pal[in_word[IDX_W-1:0]];
    end

  logic [2:0]  fmt;
  logic [23:0] col;
  logic [7:0]  la, la_e, ga_e, a_mul, a_fin;
  logic        hit;

  assign fmt = (cfg_bpp == 2'b01) ? F_IDX : cfg_mode;

  always_comb
    case (fmt)
      F_IDX: begin
        col = p1[23:0];
        la  = p1[31:24];
        hit = w1[IDX_W-1:0] == cfg_key[IDX_W-1:0];
      end
      F_565: begin
        col = {w1[15:11], w1[15:13], w1[10:5], w1[10:9], w1[4:0], w1[4:2]};
        la  = 8'hFF;
        hit = w1[15:0] == cfg_key[15:0];
      end
      F_555: begin
        col = {w1[14:10], w1[14:12], w1[9:5], w1[9:7], w1[4:0], w1[4:2]};
        la  = w1[15] ? 8'h00 : 8'hFF;
        hit = w1[15:0] == cfg_key[15:0];
      end
      F_444: begin
        col = {w1[11:8], w1[11:8], w1[7:4], w1[7:4], w1[3:0], w1[3:0]};
        la  = (|w1[15:12]) ? 8'h00 : 8'hFF;
        hit = w1[15:0] == cfg_key[15:0];
      end
      default: begin
        col = w1[23:0];
        la  = w1[31:24];
        hit = w1[23:0] == cfg_key[23:0];
      end
    endcase

  assign la_e  = cfg_lalpha_en ? la : 8'hFF;
  assign ga_e  = cfg_galpha_en ? cfg_galpha : 8'hFF;
  assign a_mul = div255(17'(la_e) * 17'(ga_e));
  assign a_fin = (cfg_key_en && hit) ? 8'h00 : a_mul;

  logic        v2, yuv2;
  logic [7:0]  a2;
  logic [23:0] col2, vid2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) v2 <= 1'b0;
    else if (go) v2 <= v1;

  always_ff @(posedge clk)
    if (go) begin
      a2   <= a_fin;
      col2 <= col;
      vid2 <= vid1;
      yuv2 <= yuv1;
    end

  logic [23:0] mix;
  for (genvar c = 0; c < 3; c++) begin : g_ch
    assign mix[c*8 +: 8] = div255(17'(a2) * 17'(col2[c*8 +: 8]) +
                                  17'(8'd255 - a2) * 17'(vid2[c*8 +: 8]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else if (go) out_valid <= v2;

  always_ff @(posedge clk)
    if (go) begin
      out_pix <= mix;
      out_yuv <= yuv2;
    end
endmodule

// File: rtl/osd_blend_chk.sv
module osd_blend_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_pix,
  input logic        out_yuv,
  input logic        go,
  input logic        v1,
  input logic        v2,
  input logic [7:0]  a2,
  input logic [23:0] col2,
  input logic [23:0] vid2
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_no_accept_when_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_yuv)));

  assert_accept_enters_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> v1);

  assert_zero_alpha_video_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && go && a2 == 8'd0) |=> (out_valid && out_pix == $past(vid2)));

  assert_full_alpha_overlay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && go && a2 == 8'd255) |=> (out_valid && out_pix == $past(col2)));
endmodule

bind osd_blend osd_blend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_yuv(out_yuv),
  .go(go), .v1(v1), .v2(v2), .a2(a2), .col2(col2), .vid2(vid2)
);

// File: tb/sim_osd_blend.sv
`timescale 1ns/1ps
module sim_osd_blend;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  cfg_mode = '0;
  logic [1:0]  cfg_bpp = '0;
  logic        cfg_key_en = 0, cfg_lalpha_en = 0, cfg_galpha_en = 0, cfg_yuv = 0;
  logic [31:0] cfg_key = '0;
  logic [7:0]  cfg_galpha = '0;
  logic        pal_wr = 0, pal_sel = 0;
  logic [31:0] pal_wdata = '0;
  logic        in_valid = 0, in_ready;
  logic [31:0] in_word = '0;
  logic [23:0] in_video = '0;
  logic        out_valid, out_ready = 1'b1, out_yuv;
  logic [23:0] out_pix;

  always #4 clk = ~clk;

  osd_blend u0 (.*);

  int checks = 0, fails = 0;
  logic [31:0] mpal [256];
  logic [7:0]  mptr = '0;
  logic [24:0] q [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned x5(input int unsigned c); return (c << 3) | (c >> 2); endfunction
  function automatic int unsigned x6(input int unsigned c); return (c << 2) | (c >> 4); endfunction

  function automatic logic [24:0] model(input logic [31:0] win, input logic [23:0] v);
    int unsigned w, la, ga, a, e, fmt;
    int unsigned o [3];
    bit hit;
    logic [23:0] pix;
    w = win;
    if (cfg_bpp == 2'd1) w = w & 32'hFF;
    else if (cfg_bpp == 2'd2) w = w & 32'hFFFF;
    fmt = (cfg_bpp == 2'd1) ? 0 : int'(cfg_mode);
    if (fmt > 4) fmt = 4;
    case (fmt)
      0: begin
        e = mpal[w & 255];
        o[0] = (e >> 16) & 255; o[1] = (e >> 8) & 255; o[2] = e & 255;
        la = e >> 24; hit = (w & 255) == (cfg_key & 255);
      end
      1: begin
        o[0] = x5((w >> 11) & 31); o[1] = x6((w >> 5) & 63); o[2] = x5(w & 31);
        la = 255; hit = (w & 16'hFFFF) == (cfg_key & 16'hFFFF);
      end
      2: begin
        o[0] = x5((w >> 10) & 31); o[1] = x5((w >> 5) & 31); o[2] = x5(w & 31);
        la = ((w >> 15) & 1) != 0 ? 0 : 255; hit = (w & 16'hFFFF) == (cfg_key & 16'hFFFF);
      end
      3: begin
        o[0] = ((w >> 8) & 15) * 17; o[1] = ((w >> 4) & 15) * 17; o[2] = (w & 15) * 17;
        la = ((w >> 12) & 15) != 0 ? 0 : 255; hit = (w & 16'hFFFF) == (cfg_key & 16'hFFFF);
      end
      default: begin
        o[0] = (w >> 16) & 255; o[1] = (w >> 8) & 255; o[2] = w & 255;
        la = w >> 24; hit = (w & 24'hFFFFFF) == (cfg_key & 24'hFFFFFF);
      end
    endcase
    if (!cfg_lalpha_en) la = 255;
    ga = cfg_galpha_en ? int'(cfg_galpha) : 255;
    a = (la * ga + 127) / 255;
    if (cfg_key_en && hit) a = 0;
    for (int c = 0; c < 3; c++) begin
      int unsigned vc;
      vc = (v >> (16 - 8*c)) & 255;
      pix[23 - 8*c -: 8] = 8'((a * o[c] + (255 - a) * vc + 127) / 255);
    end
    return {cfg_yuv, pix};
  endfunction

  task automatic pal_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    pal_wr = 1'b1; pal_sel = sel; pal_wdata = d;
    @(negedge clk);
    pal_wr = 1'b0;
    if (!sel) mptr = d[7:0]; else mpal[mptr] = d;
  endtask

  task automatic send_one(input logic [31:0] w, input logic [23:0] v, output logic [24:0] got, output int lat);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_word = w; in_video = v;
    lat = 0;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    got = {out_yuv, out_pix};
    @(negedge clk);
  endtask

  task automatic one(input logic [31:0] w, input logic [23:0] v, input logic [23:0] exp, input string req);
    logic [24:0] got;
    int lat;
    send_one(w, v, got, lat);
    chk(got[23:0] == exp, req, 32'(got[23:0]), 32'(exp));
  endtask

  task automatic one_m(input logic [31:0] w, input logic [23:0] v, input string req);
    logic [24:0] got, exp;
    int lat;
    exp = model(w, v);
    send_one(w, v, got, lat);
    chk(got == exp, req, 32'(got), 32'(exp));
  endtask

  function automatic logic [31:0] rnd_word();
    logic [31:0] w;
    w = $urandom;
    case ($urandom % 8)
      0: w[15:0] = cfg_key[15:0];
      1: w[23:0] = cfg_key[23:0];
      2: w[7:0]  = cfg_key[7:0];
      default: ;
    endcase
    return w;
  endfunction

  task automatic run_stream(input int n);
    int sent = 0, guard = 0;
    bit have = 0, held_v = 0;
    logic [31:0] w = '0;
    logic [23:0] v = '0, held = '0;
    logic [24:0] exp;
    while ((sent < n || q.size() > 0) && guard < 20000) begin
      guard++;
      @(negedge clk);
      if (held_v) chk(out_pix == held, "R9 stalled output holds", 32'(out_pix), 32'(held));
      if (!have && sent < n) begin w = rnd_word(); v = 24'($urandom); have = 1; end
      in_valid = have; in_word = w; in_video = v;
      out_ready = ($urandom % 4) != 0;
      #1;
      held_v = out_valid && !out_ready;
      held = out_pix;
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, "R9 unexpected output", 32'(out_pix), 0);
        else begin
          exp = q.pop_front();
          chk({out_yuv, out_pix} == exp, "R8/R10 random blend", 32'({out_yuv, out_pix}), 32'(exp));
        end
      end
      if (in_valid && in_ready) begin
        q.push_back(model(w, v));
        have = 0;
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    logic [24:0] got;
    int lat;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);

    for (int i = 0; i < 256; i++) begin
      pal_write(1'b0, 32'(i));
      pal_write(1'b1, $urandom);
    end

    cfg_bpp = 2'd3; cfg_mode = 3'd4;
    send_one(32'h0012_3456, 24'hABCDEF, got, lat);
    chk(got[23:0] == 24'h123456, "R8 full alpha gives overlay", 32'(got[23:0]), 32'h123456);
    chk(lat == 3, "R9 latency in edges", 32'(lat), 3);

    cfg_bpp = 2'd2; cfg_mode = 3'd1;
    one(32'h0000_FFFF, 24'h000000, 24'hFFFFFF, "R3 565 white");
    one(32'h0000_8410, 24'h000000, 24'h848284, "R3 565 expansion");
    cfg_lalpha_en = 1'b1;
    one(32'h0000_FFFF, 24'h123456, 24'hFFFFFF, "R6 565 has no local alpha");
    cfg_mode = 3'd3;
    one(32'h0000_0F84, 24'h000000, 24'hFF8844, "R3 444 expansion opaque");
    one(32'h0000_1F84, 24'h5A5A5A, 24'h5A5A5A, "R6 444 spare bit transparent");
    cfg_mode = 3'd2;
    one(32'h0000_FFFF, 24'h0A0B0C, 24'h0A0B0C, "R6 555 switch transparent");
    cfg_lalpha_en = 1'b0;
    one(32'h0000_FFFF, 24'h0A0B0C, 24'hFFFFFF, "R6 555 switch ignored when disabled");

    cfg_mode = 3'd1; cfg_key_en = 1'b1; cfg_key = 32'hFFFF_F800;
    one(32'h0000_F800, 24'h314159, 24'h314159, "R5 565 key match 16 bits");
    one_m(32'h0000_F801, 24'h314159, "R5 565 key miss");
    cfg_bpp = 2'd3; cfg_mode = 3'd4; cfg_key = 32'h00AB_CDEF;
    one(32'hFFAB_CDEF, 24'h271828, 24'h271828, "R5 8888 key 24 bits");
    cfg_key_en = 1'b0;
    one(32'hFFAB_CDEF, 24'h271828, 24'hABCDEF, "R5 key disabled");

    cfg_lalpha_en = 1'b1; cfg_galpha_en = 1'b1; cfg_galpha = 8'h80;
    one(32'hFF00_0000, 24'hFFFFFF, 24'h7F7F7F, "R7 global alpha 128");
    one(32'h8000_0000, 24'hFFFFFF, 24'hBFBFBF, "R7 product of alphas");
    cfg_galpha_en = 1'b0;

    cfg_bpp = 2'd1; cfg_mode = 3'd1;
    one_m(32'hFFFF_FF05, 24'h000000, "R2 8-bit storage forces indexed");
    cfg_bpp = 2'd2; cfg_mode = 3'd4;
    one(32'hFFFF_1234, 24'h445566, 24'h445566, "R2 16-bit storage pads upper half");

    pal_write(1'b0, 32'h0000_0007);
    pal_write(1'b1, 32'hFF11_2233);
    pal_write(1'b0, 32'h0000_0009);
    pal_write(1'b1, 32'hFF44_5566);
    pal_write(1'b1, 32'hFF77_8899);
    cfg_bpp = 2'd1;
    one(32'h0000_0007, 24'h000000, 24'h112233, "R4 palette entry 7");
    one(32'h0000_0009, 24'h000000, 24'h778899, "R4 pointer held for repeat write");

    cfg_yuv = 1'b1; cfg_bpp = 2'd3; cfg_mode = 3'd4;
    send_one(32'hFF01_0203, 24'h0, got, lat);
    chk(got[24] == 1'b1, "R10 tag carried", 32'(got[24]), 1);

    for (int r = 0; r < 10; r++) begin
      cfg_mode = 3'($urandom % 8); cfg_bpp = 2'($urandom % 4);
      cfg_key_en = 1'($urandom); cfg_lalpha_en = 1'($urandom); cfg_galpha_en = 1'($urandom);
      cfg_yuv = 1'($urandom); cfg_key = $urandom; cfg_galpha = 8'($urandom);
      run_stream(300);
    end

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule